// File: doc/BRIEF.md
# Two-Thread Allocation Arbiter with Thread-Mode Control

This block decides, every clock cycle, which of two hardware threads may place work into the shared back-end buffers: a reorder buffer and a reservation station. A thread may be picked only if it has micro-operations waiting and its share of both buffers still has room. When both threads can go, the grant alternates between them. When only one can go, that thread gets the slot whatever the turn says.

The block also keeps track of which threads are running. Halt events retire a thread. Interrupt events bring a thread back. The current mode sets the capacity each thread may use. With both threads running, each thread gets half of each buffer. With one thread running, that thread gets the whole buffer. The surrounding logic feeds in the per-thread occupancy counts and reads back the grant, the mode and the limits now in force.

Top module: `thread_alloc_arbiter`

## Requirements
- R1: After reset the mode is 0 (both threads active). The turn points at thread 0. No grant is given while no thread is eligible.
- R2: A thread is eligible only when all of these hold: its queue-not-empty input is high, its reorder occupancy is below the reorder limit, its reservation occupancy is below the reservation limit, and the thread is active in the current mode.
- R3: The grant is combinational and has at most one bit set. Bit 0 is thread 0 and bit 1 is thread 1. The thread named by the turn gets the grant if it is eligible. Otherwise the other thread gets it if that thread is eligible. No bit is set when neither thread is eligible.
- R4: After a cycle with a grant to thread t, the turn points at the other thread. A cycle with no grant leaves the turn unchanged. So when both threads stay eligible, the grants alternate cycle by cycle.
- R5: The mode encoding is 0 = both active, 1 = thread 0 only, 2 = thread 1 only, 3 = low power. In mode 0:
  - a halt from thread 1 alone moves to mode 1;
  - a halt from thread 0 alone moves to mode 2;
  - halts from both threads move to mode 3;
  - interrupts are ignored.
- R6: In mode 1 or mode 2:
  - an interrupt to the halted thread returns the block to mode 0, and this wins over a halt in the same cycle;
  - otherwise a halt from the running thread moves to mode 3;
  - a halt from the already-halted thread is ignored.
- R7: In mode 3 no grant is issued and halts are ignored. An interrupt to thread 0 alone moves to mode 1. An interrupt to thread 1 alone moves to mode 2. Interrupts to both threads move to mode 0.
- R8: In mode 0 the limits are half of each buffer depth. In every other mode the limits are the full depths. With the default depths of 32 and 16, mode 0 gives 16 and 8, and any other mode gives 32 and 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| qNotEmpty | input | 2 | Per-thread queue holds work (bit t = thread t) |
| robOcc0 | input | $clog2(ROB_DEPTH+1) | Reorder entries held by thread 0 |
| robOcc1 | input | $clog2(ROB_DEPTH+1) | Reorder entries held by thread 1 |
| rsOcc0 | input | $clog2(RS_DEPTH+1) | Reservation entries held by thread 0 |
| rsOcc1 | input | $clog2(RS_DEPTH+1) | Reservation entries held by thread 1 |
| halt | input | 2 | Per-thread halt event |
| intr | input | 2 | Per-thread interrupt event |
| grant | output | 2 | One-hot allocation grant, or zero |
| mode | output | 2 | Current thread mode |
| robLimit | output | $clog2(ROB_DEPTH+1) | Per-thread reorder limit in force |
| rsLimit | output | $clog2(RS_DEPTH+1) | Per-thread reservation limit in force |

## Verification
Two situations are hard to reach from the ports. The first is a single-thread mode in which the halted thread's interrupt and the running thread's halt arrive in the same cycle. The second is an occupancy that sits between the half and the full limit, which is legal only after recombination. The stimulus table reaches both by chaining halts from mode 0 into a single-thread mode before applying those values. Out-of-turn grants are placed just before alternating cycles, so the turn-pointer update is visible at the grant output. A reset applied in the middle of a single-thread run, with the turn parked at thread 1, shows that both the mode and the turn are cleared.

// File: rtl/thread_alloc_pkg.sv
`timescale 1ns/1ps
package thread_alloc_pkg;

  typedef enum logic [1:0] {
    MODE_DUAL  = 2'd0,
    MODE_SOLO0 = 2'd1,
    MODE_SOLO1 = 2'd2,
    MODE_NAP   = 2'd3
  } threadMode_e;

  // Strobes from the control unit to the capacity datapath
  typedef struct packed {
    logic [1:0] threadOn;   // thread t may allocate in this mode
    logic       splitCap;   // halve the per-thread limits
  } ctrlStrobe_t;

endpackage

// File: rtl/thread_alloc_dp.sv
`timescale 1ns/1ps
module thread_alloc_dp
  import thread_alloc_pkg::*;
#(
  parameter int ROB_DEPTH = 32,
  parameter int RS_DEPTH  = 16
) (
  input  ctrlStrobe_t                       strobe,
  input  logic [1:0]                        qNotEmpty,
  input  logic [$clog2(ROB_DEPTH+1)-1:0]    robOcc0,
  input  logic [$clog2(ROB_DEPTH+1)-1:0]    robOcc1,
  input  logic [$clog2(RS_DEPTH+1)-1:0]     rsOcc0,
  input  logic [$clog2(RS_DEPTH+1)-1:0]     rsOcc1,
  output logic [1:0]                        elig,
  output logic [$clog2(ROB_DEPTH+1)-1:0]    robLimit,
  output logic [$clog2(RS_DEPTH+1)-1:0]     rsLimit
);
  localparam int ROB_W = $clog2(ROB_DEPTH+1);
  localparam int RS_W  = $clog2(RS_DEPTH+1);
  localparam int NUM_THREADS = 2;

  logic [ROB_W-1:0] robOccArr [NUM_THREADS];
  logic [RS_W-1:0]  rsOccArr  [NUM_THREADS];

  assign robOccArr[0] = robOcc0;
  assign robOccArr[1] = robOcc1;
  assign rsOccArr[0]  = rsOcc0;
  assign rsOccArr[1]  = rsOcc1;

  // Partitioned or recombined capacity (R8)
  always_comb begin
    robLimit = strobe.splitCap ? ROB_W'(ROB_DEPTH / 2) : ROB_W'(ROB_DEPTH);
    rsLimit  = strobe.splitCap ? RS_W'(RS_DEPTH / 2)   : RS_W'(RS_DEPTH);
  end

  // Per-thread eligibility (R2)
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_elig
    assign elig[t] = strobe.threadOn[t] & qNotEmpty[t]
                   & (robOccArr[t] < robLimit)
                   & (rsOccArr[t] < rsLimit);
  end

endmodule

// File: rtl/thread_alloc_ctrl.sv
`timescale 1ns/1ps
module thread_alloc_ctrl
  import thread_alloc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  halt,
  input  logic [1:0]  intr,
  input  logic [1:0]  elig,
  output logic [1:0]  grant,
  output threadMode_e mode,
  output ctrlStrobe_t strobe
);
  threadMode_e modeQ, modeD;
  logic        turnQ;

  // Mode machine (R5, R6, R7)
  always_comb begin
    modeD = modeQ;
    unique case (modeQ)
      MODE_DUAL: begin
        unique case (halt)
          2'b10:   modeD = MODE_SOLO0;
          2'b01:   modeD = MODE_SOLO1;
          2'b11:   modeD = MODE_NAP;
          default: modeD = MODE_DUAL;
        endcase
      end
      MODE_SOLO0: begin
        if (intr[1])      modeD = MODE_DUAL;
        else if (halt[0]) modeD = MODE_NAP;
      end
      MODE_SOLO1: begin
        if (intr[0])      modeD = MODE_DUAL;
        else if (halt[1]) modeD = MODE_NAP;
      end
      MODE_NAP: begin
        unique case (intr)
          2'b01:   modeD = MODE_SOLO0;
          2'b10:   modeD = MODE_SOLO1;
          2'b11:   modeD = MODE_DUAL;
          default: modeD = MODE_NAP;
        endcase
      end
      default: modeD = MODE_DUAL;
    endcase
  end

  // Turn-first grant with fallback to the other thread (R3)
  always_comb begin
    grant = 2'b00;
    if (elig[turnQ])       grant[turnQ]  = 1'b1;
    else if (elig[~turnQ]) grant[~turnQ] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      modeQ <= MODE_DUAL;
      turnQ <= 1'b0;
    end else begin
      modeQ <= modeD;
      if (|grant) turnQ <= grant[0];   // R4: point at the thread not just served
    end
  end

  always_comb begin
    mode = modeQ;
    unique case (modeQ)
      MODE_DUAL:  strobe.threadOn = 2'b11;
      MODE_SOLO0: strobe.threadOn = 2'b01;
      MODE_SOLO1: strobe.threadOn = 2'b10;
      default:    strobe.threadOn = 2'b00;
    endcase
    strobe.splitCap = (modeQ == MODE_DUAL);
  end

  // Assertions
  a_r3_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  a_r3_grant_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~elig) == 2'b00);
  a_r3_no_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (|elig) |-> (|grant));
  a_r4_alternate_0to1: assert property (@(posedge clk) disable iff (!rst_n)
    ((&elig) && grant[0]) ##1 (&elig) |-> grant[1]);
  a_r4_alternate_1to0: assert property (@(posedge clk) disable iff (!rst_n)
    ((&elig) && grant[1]) ##1 (&elig) |-> grant[0]);
  a_r5_t1_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_DUAL && halt == 2'b10) |=> (mode == MODE_SOLO0));
  a_r6_solo_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SOLO0 && halt[0] && !intr[1]) |=> (mode == MODE_NAP));
  a_r6_solo_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SOLO1 && intr[0]) |=> (mode == MODE_DUAL));
  a_r7_nap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_NAP) |-> (grant == 2'b00));
  a_r7_wake_t0: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_NAP && intr == 2'b01) |=> (mode == MODE_SOLO0));

endmodule

// File: rtl/thread_alloc_arbiter.sv
`timescale 1ns/1ps
module thread_alloc_arbiter
  import thread_alloc_pkg::*;
#(
  parameter int ROB_DEPTH = 32,
  parameter int RS_DEPTH  = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [1:0]                        qNotEmpty,
  input  logic [$clog2(ROB_DEPTH+1)-1:0]    robOcc0,
  input  logic [$clog2(ROB_DEPTH+1)-1:0]    robOcc1,
  input  logic [$clog2(RS_DEPTH+1)-1:0]     rsOcc0,
  input  logic [$clog2(RS_DEPTH+1)-1:0]     rsOcc1,
  input  logic [1:0]                        halt,
  input  logic [1:0]                        intr,
  output logic [1:0]                        grant,
  output logic [1:0]                        mode,
  output logic [$clog2(ROB_DEPTH+1)-1:0]    robLimit,
  output logic [$clog2(RS_DEPTH+1)-1:0]     rsLimit
);
  ctrlStrobe_t strobe;
  threadMode_e modeCur;
  logic [1:0]  elig;

  thread_alloc_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .halt   (halt),
    .intr   (intr),
    .elig   (elig),
    .grant  (grant),
    .mode   (modeCur),
    .strobe (strobe)
  );

  thread_alloc_dp #(
    .ROB_DEPTH (ROB_DEPTH),
    .RS_DEPTH  (RS_DEPTH)
  ) u_dp (
    .strobe    (strobe),
    .qNotEmpty (qNotEmpty),
    .robOcc0   (robOcc0),
    .robOcc1   (robOcc1),
    .rsOcc0    (rsOcc0),
    .rsOcc1    (rsOcc1),
    .elig      (elig),
    .robLimit  (robLimit),
    .rsLimit   (rsLimit)
  );

  assign mode = modeCur;

endmodule

// File: tb/thread_alloc_arbiter_tb.sv
`timescale 1ns/1ps
module thread_alloc_arbiter_tb;

  localparam int ROB_DEPTH = 32;
  localparam int RS_DEPTH  = 16;
  localparam int NVEC      = 25;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] qNotEmpty = '0;
  logic [5:0] robOcc0 = '0, robOcc1 = '0;
  logic [4:0] rsOcc0 = '0, rsOcc1 = '0;
  logic [1:0] halt = '0, intr = '0;
  logic [1:0] grant, mode;
  logic [5:0] robLimit;
  logic [4:0] rsLimit;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  thread_alloc_arbiter #(.ROB_DEPTH(ROB_DEPTH), .RS_DEPTH(RS_DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .qNotEmpty(qNotEmpty),
    .robOcc0(robOcc0), .robOcc1(robOcc1), .rsOcc0(rsOcc0), .rsOcc1(rsOcc1),
    .halt(halt), .intr(intr), .grant(grant), .mode(mode),
    .robLimit(robLimit), .rsLimit(rsLimit)
  );

  // {qne, rob0, rob1, rs0, rs1, halt, intr, expected grant, expected mode after edge}
  localparam logic [31:0] VEC [NVEC] = '{
    {2'b00, 6'd0,  6'd0,  5'd0,  5'd0,  2'b00, 2'b00, 2'b00, 2'd0}, // R1 idle
    {2'b11, 6'd0,  6'd0,  5'd0,  5'd0,  2'b00, 2'b00, 2'b01, 2'd0}, // R4 alternate
    {2'b11, 6'd0,  6'd0,  5'd0,  5'd0,  2'b00, 2'b00, 2'b10, 2'd0}, // R4
    {2'b11, 6'd0,  6'd0,  5'd0,  5'd0,  2'b00, 2'b00, 2'b01, 2'd0}, // R4
    {2'b01, 6'd0,  6'd0,  5'd0,  5'd0,  2'b00, 2'b00, 2'b01, 2'd0}, // R3 out of turn
    {2'b11, 6'd16, 6'd0,  5'd0,  5'd0,  2'b00, 2'b00, 2'b10, 2'd0}, // R2 rob0 at half
    {2'b11, 6'd0,  6'd0,  5'd0,  5'd8,  2'b00, 2'b00, 2'b01, 2'd0}, // R2 rs1 at half
    {2'b11, 6'd15, 6'd15, 5'd7,  5'd7,  2'b00, 2'b00, 2'b10, 2'd0}, // R2 just below
    {2'b11, 6'd0,  6'd0,  5'd0,  5'd0,  2'b10, 2'b00, 2'b01, 2'd1}, // R5 t1 halt
    {2'b11, 6'd20, 6'd0,  5'd10, 5'd0,  2'b10, 2'b00, 2'b01, 2'd1}, // R8 R6 full cap
    {2'b11, 6'd32, 6'd0,  5'd0,  5'd0,  2'b00, 2'b00, 2'b00, 2'd1}, // R2 rob0 full
    {2'b01, 6'd0,  6'd0,  5'd0,  5'd0,  2'b01, 2'b00, 2'b01, 2'd3}, // R6 to low power
    {2'b11, 6'd0,  6'd0,  5'd0,  5'd0,  2'b11, 2'b00, 2'b00, 2'd3}, // R7 halts ignored
    {2'b11, 6'd0,  6'd0,  5'd0,  5'd0,  2'b00, 2'b10, 2'b00, 2'd2}, // R7 wake t1
    {2'b11, 6'd0,  6'd31, 5'd0,  5'd15, 2'b00, 2'b00, 2'b10, 2'd2}, // R8 full cap t1
    {2'b11, 6'd0,  6'd0,  5'd0,  5'd0,  2'b10, 2'b01, 2'b10, 2'd0}, // R6 intr beats halt
    {2'b11, 6'd0,  6'd0,  5'd0,  5'd0,  2'b00, 2'b11, 2'b01, 2'd0}, // R5 intr ignored
    {2'b00, 6'd0,  6'd0,  5'd0,  5'd0,  2'b01, 2'b00, 2'b00, 2'd2}, // R5 t0 halt
    {2'b00, 6'd0,  6'd0,  5'd0,  5'd0,  2'b10, 2'b00, 2'b00, 2'd3}, // R6
    {2'b00, 6'd0,  6'd0,  5'd0,  5'd0,  2'b00, 2'b01, 2'b00, 2'd1}, // R7 wake t0
    {2'b00, 6'd0,  6'd0,  5'd0,  5'd0,  2'b01, 2'b00, 2'b00, 2'd3}, // R6
    {2'b00, 6'd0,  6'd0,  5'd0,  5'd0,  2'b00, 2'b11, 2'b00, 2'd0}, // R7 wake both
    {2'b00, 6'd0,  6'd0,  5'd0,  5'd0,  2'b11, 2'b00, 2'b00, 2'd3}, // R5 both halt
    {2'b00, 6'd0,  6'd0,  5'd0,  5'd0,  2'b00, 2'b11, 2'b00, 2'd0}, // R7
    {2'b10, 6'd0,  6'd0,  5'd0,  5'd0,  2'b00, 2'b00, 2'b10, 2'd0}  // R3 turn at t1
  };

  task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic checkLimits(input logic [1:0] expMode);
    check(8'(robLimit), (expMode == 2'd0) ? 8'(ROB_DEPTH/2) : 8'(ROB_DEPTH), "R8 rob limit");
    check(8'(rsLimit),  (expMode == 2'd0) ? 8'(RS_DEPTH/2)  : 8'(RS_DEPTH),  "R8 rs limit");
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R1 reset state
    check(8'(mode), 8'd0, "R1 mode after reset");
    check(8'(grant), 8'd0, "R1 grant idle");
    checkLimits(2'd0);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      {qNotEmpty, robOcc0, robOcc1, rsOcc0, rsOcc1, halt, intr} = VEC[i][31:4];
      #1;
      check(8'(grant), 8'(VEC[i][3:2]), "R2/R3/R4 grant");
      @(posedge clk);
      #1;
      check(8'(mode), 8'(VEC[i][1:0]), "R5/R6/R7 mode");
      checkLimits(VEC[i][1:0]);
    end

    // R1: reset mid-run clears mode and turn; park turn at thread 1 first
    @(negedge clk);
    qNotEmpty = 2'b01; halt = 2'b10; intr = 2'b00;
    robOcc0 = '0; robOcc1 = '0; rsOcc0 = '0; rsOcc1 = '0;
    #1 check(8'(grant), 8'b01, "R3 grant before reset");
    @(posedge clk); #1;
    check(8'(mode), 8'd1, "R5 mode before reset");
    @(negedge clk);
    halt = 2'b00; qNotEmpty = 2'b00; rst_n = 1'b0;
    @(posedge clk); #1;
    check(8'(mode), 8'd0, "R1 mode after mid reset");
    checkLimits(2'd0);
    @(negedge clk);
    rst_n = 1'b1; qNotEmpty = 2'b11;
    #1 check(8'(grant), 8'b01, "R1 turn reset to thread 0");
    @(posedge clk); #1;
    @(negedge clk);
    #1 check(8'(grant), 8'b10, "R4 alternation after reset");

    finishRun();
  end

endmodule